// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects thirteen interrupt request sources, sorts them into eight vectored groups, and offers the CPU one request at a time together with its vector address. Four of the sources are external pins. Each pin passes through a two-stage synchronizer and then a trigger detector, and each pin has its own legal set of trigger modes. The other nine sources are single-cycle request pulses from on-chip peripherals. Each pulse is latched into a pending flag.

Every group carries a priority tier. There are three tiers: low, high and top. Only the two highest-ranked external groups can be raised to the top tier, and the other six groups choose between low and high. The controller keeps track of the tier now in service. It offers a request only when that request ranks strictly above the tier in service, which lets a higher tier interrupt a lower one. Acknowledge pushes the current tier onto a small stack, and return-from-interrupt pops it.

Top module: `intc_top`

## Requirements
- R1: During and after reset, nothing is pending, `irq_valid` is low and no tier is in service.
- R2: Pending bits and groups are numbered as follows. Bit 0 is pin 0 (group 0). Bit 1 is pin 1 (group 1). Bit 2 is pin 2 and bit 3 is per_req[0] (group 2). Bit 4 is pin 3 and bit 5 is per_req[1] (group 3). Bit 6 is per_req[2] (group 4). Bits 7 and 8 are per_req[3..4] (group 5). Bits 9 and 10 are per_req[5..6] (group 6). Bits 11 and 12 are per_req[7..8] (group 7).
- R3: The vector address is 8'h03 + 8 × group, so it runs 03h, 0Bh, 13h, 1Bh and so on up to 3Bh.
- R4: Pins 0 and 1 use a 2-bit mode field: 00 is rising edge, 01 is falling edge, 10 is high level, 11 is low level. In a level mode the pending bit follows the synchronized pin and is not latched.
- R5: Pins 2 and 3 use a 2-bit mode field: 00 is rising edge, 01 is falling edge, and 10 or 11 is both edges. These pins have no level mode.
- R6: An edge or peripheral pending bit stays set until its `clr_pend` bit is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R7: When a source's `src_en` bit is low, the source still latches its pending bit but does not request service.
- R8: For groups 0 and 1, `grp_hi` selects the top tier instead of low. For groups 2 to 7, `grp_hi` selects high instead of low.
- R9: `irq_valid` is high only when the best request ranks strictly above the tier in service. Acknowledging a valid request raises the tier in service to that request's tier.
- R10: Return-from-interrupt restores the tier that was in service before the matching acknowledge. A return with nothing in service is ignored.
- R11: Among requesting groups of the same tier, the lowest group number wins.
- R12: A pin edge shows in `pend` three clocks after the pin changes. A level shows two clocks after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 4 | Raw external request pins, asynchronous |
| per_req | input | 9 | Single-cycle peripheral request pulses |
| trig_mode | input | 8 | Trigger mode, 2 bits per pin; pin p uses bits [2p+1:2p] |
| src_en | input | 13 | Per-source request enable |
| grp_hi | input | 8 | Per-group tier select |
| clr_pend | input | 13 | Per-source pending clear pulses |
| pend | output | 13 | Per-source pending flags (level sources shown live) |
| irq_valid | output | 1 | A request above the tier in service is offered |
| irq_vec | output | 8 | Vector address of the offered request |
| irq_ack | input | 1 | CPU accepts the offered request |
| irq_ret | input | 1 | CPU returns from the current handler |

## Verification
The bench checks the synchronizer latency cycle by cycle. A detector that skipped a stage, or took edges from the unsynchronized pin, would set the pending bit one clock early. It also covers the trigger modes that are illegal on one pin and legal on another. If pins 2 and 3 fell into level mode on codes 10 and 11, they would keep requesting after a clear instead of waiting for the next edge. Nesting is driven through acknowledge, preemption by a top-tier pin, and a chain of returns that ends with a return on an empty stack. A stack that underflowed would leave a stale tier in service, and a later acknowledge would then fail to block a lower request. Same-tier ties and a same-cycle set and clear are also checked. These would catch an arbiter that favoured high group numbers and a pending bit that let the clear win.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC = 13;
    localparam int NGRP = 8;
    localparam int NPIN = 4;
    localparam int NPER = 9;

    typedef enum logic [1:0] {LV_NONE = 2'd0, LV_LOW = 2'd1, LV_HIGH = 2'd2, LV_TOP = 2'd3} lvl_e;

    localparam logic [7:0] VEC_BASE = 8'h03;

    // group number of each pending bit
    function automatic int grp_of(input int s);
        case (s)
            0:       return 0;
            1:       return 1;
            2, 3:    return 2;
            4, 5:    return 3;
            6:       return 4;
            7, 8:    return 5;
            9, 10:   return 6;
            default: return 7;
        endcase
    endfunction

    // pending bit fed by external pin p
    function automatic int pin_src(input int p);
        return (p == 3) ? 4 : p;
    endfunction

    // pending bit fed by peripheral pulse k
    function automatic int per_src(input int k);
        case (k)
            0:       return 3;
            1:       return 5;
            default: return k + 4;
        endcase
    endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/intc_trig.sv
module intc_trig #(
    parameter bit LVL_OK = 1'b1
) (
    input  logic       cur,
    input  logic       prev,
    input  logic [1:0] mode,
    output logic       edge_hit,
    output logic       lvl_mode,
    output logic       lvl_act
);
    logic rise, fall;

    always_comb begin
        rise     = cur & ~prev;
        fall     = ~cur & prev;
        edge_hit = 1'b0;
        lvl_mode = 1'b0;
        lvl_act  = 1'b0;
        case (mode)
            2'b00:   edge_hit = rise;
            2'b01:   edge_hit = fall;
            default: begin
                if (LVL_OK) begin
                    lvl_mode = 1'b1;
                    lvl_act  = mode[0] ? ~cur : cur;
                end else begin
                    edge_hit = rise | fall;
                end
            end
        endcase
    end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
    parameter int NG = 8,
    localparam int GW = $clog2(NG)
) (
    input  logic [NG-1:0]      greq,
    input  logic [NG-1:0][1:0] glvl,
    output logic [1:0]         best_lvl,
    output logic [GW-1:0]      best_idx
);
    always_comb begin
        best_lvl = 2'd0;
        best_idx = '0;
        // scan downward so that ties settle on the lowest group
        for (int g = NG - 1; g >= 0; g--) begin
            if (greq[g] && glvl[g] >= best_lvl) begin
                best_lvl = glvl[g];
                best_idx = GW'(g);
            end
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int NEST        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] ext_pin,
    input  logic [NPER-1:0] per_req,
    input  logic [2*NPIN-1:0] trig_mode,
    input  logic [NSRC-1:0] src_en,
    input  logic [NGRP-1:0] grp_hi,
    input  logic [NSRC-1:0] clr_pend,
    output logic [NSRC-1:0] pend,
    output logic            irq_valid,
    output logic [7:0]      irq_vec,
    input  logic            irq_ack,
    input  logic            irq_ret
);
    localparam int SPW = $clog2(NEST + 1);
    localparam int IW  = $clog2(NEST);
    localparam int GW  = $clog2(NGRP);

    typedef struct packed {
        logic [NSRC-1:0]      pend;
        logic [NPIN-1:0]      prev;
        logic [1:0]           lvl;
        logic [SPW-1:0]       sp;
        logic [NEST-1:0][1:0] stk;
    } st_t;

    st_t st_d, st_q;

    logic [NPIN-1:0] pin_s, e_hit, l_mode, l_act;
    logic [NSRC-1:0] set_v, lvl_mask, live, pend_vis, req_src;
    logic [NGRP-1:0] greq;
    logic [NGRP-1:0][1:0] glvl;
    logic [1:0]      best_lvl;
    logic [GW-1:0]   best_idx;
    logic [1:0]      lvl_now;
    logic [SPW-1:0]  sp_now;

    intc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_pin), .dout(pin_s)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        intc_trig #(.LVL_OK(p < 2)) u_trig (
            .cur(pin_s[p]), .prev(st_q.prev[p]), .mode(trig_mode[2*p +: 2]),
            .edge_hit(e_hit[p]), .lvl_mode(l_mode[p]), .lvl_act(l_act[p])
        );
    end

    intc_arb #(.NG(NGRP)) u_arb (
        .greq(greq), .glvl(glvl), .best_lvl(best_lvl), .best_idx(best_idx)
    );

    always_comb begin
        set_v    = '0;
        lvl_mask = '0;
        live     = '0;
        for (int p = 0; p < NPIN; p++) begin
            set_v[pin_src(p)]    = e_hit[p];
            lvl_mask[pin_src(p)] = l_mode[p];
            live[pin_src(p)]     = l_act[p];
        end
        for (int k = 0; k < NPER; k++) set_v[per_src(k)] = per_req[k];

        pend_vis = (st_q.pend & ~lvl_mask) | live;
        req_src  = pend_vis & src_en;

        greq = '0;
        for (int s = 0; s < NSRC; s++) greq[grp_of(s)] |= req_src[s];
        for (int g = 0; g < NGRP; g++) begin
            if (!grp_hi[g])  glvl[g] = LV_LOW;
            else if (g < 2)  glvl[g] = LV_TOP;
            else             glvl[g] = LV_HIGH;
        end

        irq_valid = best_lvl > st_q.lvl;
        irq_vec   = VEC_BASE + {best_idx, 3'b000};

        st_d      = st_q;
        st_d.prev = pin_s;
        st_d.pend = ((st_q.pend & ~clr_pend) | set_v) & ~lvl_mask;
        if (irq_ret) begin
            if (st_q.sp != '0) begin
                st_d.lvl = st_q.stk[IW'(st_q.sp - 1'b1)];
                st_d.sp  = st_q.sp - 1'b1;
            end
        end else if (irq_ack && irq_valid && st_q.sp < SPW'(NEST)) begin
            st_d.stk[IW'(st_q.sp)] = st_q.lvl;
            st_d.sp                = st_q.sp + 1'b1;
            st_d.lvl               = best_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend    = pend_vis;
    assign lvl_now = st_q.lvl;
    assign sp_now  = st_q.sp;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int NSRC = 13,
    parameter int SPW  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] clr_pend,
    input logic            irq_valid,
    input logic [7:0]      irq_vec,
    input logic            irq_ack,
    input logic            irq_ret,
    input logic [1:0]      lvl,
    input logic [SPW-1:0]  sp
);
    localparam logic [NSRC-1:0] PER_MASK = 13'h1FE8;

    AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vec[2:0] == 3'b011 && irq_vec <= 8'h3B)); // R3

    AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid && !irq_ret) |=> (lvl > $past(lvl))); // R9

    AST_RET_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && sp != '0) |=> (lvl < $past(lvl))); // R10

    AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'd3) |-> !irq_valid); // R9

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~$past(clr_pend) & PER_MASK) & ~pend) == '0)); // R6
endmodule

bind intc_top intc_chk #(.NSRC(intc_pkg::NSRC), .SPW($clog2(NEST + 1))) u_chk (
    .clk(clk), .rst_n(rst_n), .pend(pend), .clr_pend(clr_pend),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .lvl(lvl_now), .sp(sp_now)
);

// File: tb/intc_top_bench.sv
module intc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext_pin = '0;
    logic [8:0]  per_req = '0;
    logic [7:0]  trig_mode = '0;
    logic [12:0] src_en = '1;
    logic [7:0]  grp_hi = '0;
    logic [12:0] clr_pend = '0;
    logic [12:0] pend;
    logic        irq_valid;
    logic [7:0]  irq_vec;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        int          sel;   // 0: interrupt offer, 1: masked pending bits
        logic [12:0] mask;
        logic [12:0] exp;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_top u_intc_top (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .per_req(per_req),
        .trig_mode(trig_mode), .src_en(src_en), .grp_hi(grp_hi),
        .clr_pend(clr_pend), .pend(pend), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [12:0] act;
                it = sb_q.pop_front();
                if (it.sel == 0) act = irq_valid ? {4'b0, 1'b1, irq_vec} : 13'h0;
                else             act = pend & it.mask;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic exp_irq(input bit v, input logic [7:0] vec, input string tag);
        item_t it;
        it.tag = tag; it.sel = 0; it.mask = '0;
        it.exp = v ? {4'b0, 1'b1, vec} : 13'h0;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic exp_pend(input logic [12:0] m, input logic [12:0] v, input string tag);
        item_t it;
        it.tag = tag; it.sel = 1; it.mask = m; it.exp = v & m;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic clr(input logic [12:0] m);
        clr_pend = m;
        tick(1);
        clr_pend = '0;
    endtask

    task automatic pulse(input logic [8:0] m);
        per_req = m;
        tick(1);
        per_req = '0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(2);
        exp_pend(13'h1FFF, 13'h0, "R1 pending in reset");
        exp_irq(0, 8'h0, "R1 no request in reset");
        rst_n = 1'b1;
        tick(2);
        exp_pend(13'h1FFF, 13'h0, "R1 pending after reset");
        exp_irq(0, 8'h0, "R1 no request after reset");

        // pin 0 rising edge, latency and vector
        ext_pin[0] = 1'b1;
        tick(2);
        exp_pend(13'h0001, 13'h0000, "R12 edge not yet after two clocks");
        tick(1);
        exp_pend(13'h0001, 13'h0001, "R12 R4 rising edge pin0 pending");
        exp_irq(1, 8'h03, "R3 vector group0");
        clr(13'h0001);
        exp_irq(0, 8'h0, "R6 clear removes pin0 pending");
        ext_pin[0] = 1'b0;
        tick(3);
        exp_pend(13'h0001, 13'h0000, "R4 falling ignored in rising mode");

        // pin 1 level modes
        trig_mode[3:2] = 2'b10;
        ext_pin[1] = 1'b1;
        tick(2);
        exp_pend(13'h0002, 13'h0002, "R12 R4 high level visible");
        exp_irq(1, 8'h0B, "R3 vector group1");
        clr(13'h0002);
        exp_pend(13'h0002, 13'h0002, "R4 clear has no effect on level");
        ext_pin[1] = 1'b0;
        tick(2);
        exp_pend(13'h0002, 13'h0000, "R4 level follows pin low");
        trig_mode[3:2] = 2'b11;
        tick(1);
        exp_pend(13'h0002, 13'h0002, "R4 low level active");
        trig_mode[3:2] = 2'b00;
        tick(1);
        exp_pend(13'h0002, 13'h0000, "R4 back to edge mode not latched");

        // pin 2 both edges
        trig_mode[5:4] = 2'b10;
        ext_pin[2] = 1'b1;
        tick(3);
        exp_pend(13'h0004, 13'h0004, "R5 both-edge rise");
        exp_irq(1, 8'h13, "R3 vector group2");
        clr(13'h0004);
        tick(2);
        exp_pend(13'h0004, 13'h0000, "R5 no level mode on pin2");
        ext_pin[2] = 1'b0;
        tick(3);
        exp_pend(13'h0004, 13'h0004, "R5 both-edge fall");
        clr(13'h0004);
        trig_mode[5:4] = 2'b01;
        ext_pin[2] = 1'b1;
        tick(3);
        exp_pend(13'h0004, 13'h0000, "R5 rise ignored in falling mode");
        ext_pin[2] = 1'b0;
        tick(3);
        exp_pend(13'h0004, 13'h0004, "R5 falling mode fires");
        clr(13'h0004);

        // pin 3 code 11 is both edges
        trig_mode[7:6] = 2'b11;
        ext_pin[3] = 1'b1;
        tick(3);
        exp_pend(13'h0010, 13'h0010, "R5 R2 pin3 code11 rise");
        exp_irq(1, 8'h1B, "R3 vector group3");
        clr(13'h0010);
        ext_pin[3] = 1'b0;
        tick(3);
        exp_pend(13'h0010, 13'h0010, "R5 pin3 code11 fall");
        clr(13'h0010);

        // enable masking, mapping and ties
        src_en[6] = 1'b0;
        pulse(9'h004);
        exp_pend(13'h0040, 13'h0040, "R7 R2 masked source still latches");
        exp_irq(0, 8'h0, "R7 masked source does not request");
        src_en[6] = 1'b1;
        tick(1);
        exp_irq(1, 8'h23, "R2 R3 per_req2 in group4");
        pulse(9'h080);
        exp_irq(1, 8'h23, "R11 lower group wins tie");
        clr(13'h0040);
        exp_irq(1, 8'h3B, "R2 per_req7 in group7");
        per_req = 9'h080;
        clr(13'h0800);
        per_req = '0;
        exp_pend(13'h0800, 13'h0800, "R6 set wins over clear");
        clr(13'h0800);
        exp_pend(13'h0800, 13'h0000, "R6 clear alone");
        pulse(9'h100);
        exp_irq(1, 8'h3B, "R2 per_req8 in group7");
        clr(13'h1000);

        // tiers and nesting
        pulse(9'h012);
        exp_irq(1, 8'h1B, "R11 group3 beats group5 at low");
        grp_hi[5] = 1'b1;
        tick(1);
        exp_irq(1, 8'h2B, "R8 high tier beats lower group");
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        exp_irq(0, 8'h0, "R9 same tier blocked after ack");
        ext_pin[0] = 1'b1;
        tick(3);
        ext_pin[0] = 1'b0;
        exp_irq(0, 8'h0, "R9 low pin0 below tier in service");
        grp_hi[0] = 1'b1;
        tick(1);
        exp_irq(1, 8'h03, "R8 pin0 top tier preempts");
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        exp_irq(0, 8'h0, "R9 nothing above top tier");
        clr(13'h0001);
        irq_ret = 1'b1;
        tick(1);
        exp_irq(0, 8'h0, "R10 first return restores high");
        tick(1);
        exp_irq(1, 8'h2B, "R10 second return restores none");
        tick(1);
        irq_ret = 1'b0;
        exp_irq(1, 8'h2B, "R10 return on empty stack ignored");
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        exp_irq(0, 8'h0, "R10 ack after empty return blocks low");

        done = 1'b1;
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule